// File: doc/BRIEF.md
# Nibble Ripple Arithmetic Slice

This block is a four-bit arithmetic slice that chains to its neighbours through a single carry wire. Each slice takes two five-bit operand buses, a fast carry input and a small set of configuration inputs. It produces a four-bit result and one carry. The configuration picks one of four functions:

- add or subtract
- count up or down
- multiply-accumulate for one bit of a partial product
- an equality compare whose "unequal" flag ripples down the carry chain

Wide datapaths are built by feeding each slice's carry output into the fast carry input of the next slice. Every slice can take its incoming carry from that fast input, from the top bit of its second operand, or from a constant 0 or 1. The final carry can be routed to the dedicated carry pin, to an auxiliary output, or to both. For counters, an internal four-bit count register can be loaded from the result on enabled clocks. When loop-back is selected, that register replaces the first operand, so the slice counts on its own.

Top module: `nib_arith_slice`

## Requirements
- R1: The slice carry-in is chosen by `cin_src`: 0 takes `fast_cin`, 1 takes `op_b[4]`, 2 forces 0, 3 forces 1.
- R2: With `mode_sel`=0 and `op_a[4]`=0, `res_f` is the low four bits of A[3:0]+B[3:0]+carry-in, and the slice carry is bit 4 of that sum.
- R3: With `mode_sel`=0 and `op_a[4]`=1, the slice adds A[3:0], the bitwise inverse of B[3:0] and the carry-in. With carry-in 1 this gives A−B, and the slice carry is 1 exactly when A≥B (no borrow).
- R4: With `mode_sel`=1 and `op_a[4]`=1, `res_f` is A[3:0] plus the carry-in, and the slice carry is 1 only when A is 15 and the carry-in is 1.
- R5: With `mode_sel`=1 and `op_a[4]`=0, `res_f` is A[3:0] minus the carry-in, and the slice carry is 1 only when A is 0 and the carry-in is 1. This carry is a borrow that the next slice consumes.
- R6: With `mode_sel`=2, `res_f` is A[3:0]+B[3:0]+carry-in when `op_a[4]`=1. When `op_a[4]`=0 it is A[3:0]+carry-in. The slice carry is the overflow out of bit 3.
- R7: With `mode_sel`=3, `res_f` is A[3:0] XOR B[3:0]. The slice carry is 1 when A[3:0]≠B[3:0] or when the selected carry-in is 1.
- R8: `carry_route` bit 0 enables `cout` and bit 1 enables `aux_out`; a disabled output drives 0.
- R9: `cnt_q` is 0 under reset. It loads `res_f` on a rising clock edge only when `cnt_en`=1 and `mode_sel`=1; at any other time it holds its value.
- R10: With `mode_sel`=1 and `cnt_loop`=1, `cnt_q` replaces A[3:0] as the count input. In every other mode `cnt_loop` has no effect on `res_f`.
- R11: Four slices chained from carry output to `fast_cin` perform 16-bit add, subtract, count and equality compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the count register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 5 | Operand A; bit 4 is the per-mode control bit |
| op_b | input | 5 | Operand B; bit 4 is an optional carry source |
| fast_cin | input | 1 | Carry from the previous slice |
| mode_sel | input | 2 | 0 add/sub, 1 counter, 2 multiply-accumulate, 3 equality |
| cin_src | input | 2 | Carry-in source select |
| carry_route | input | 2 | Bit 0 drives cout, bit 1 drives aux_out |
| cnt_loop | input | 1 | Counter takes its count from cnt_q |
| cnt_en | input | 1 | Count register load enable |
| res_f | output | 4 | Slice result |
| cout | output | 1 | Dedicated carry output |
| aux_out | output | 1 | Auxiliary carry mirror |
| cnt_q | output | 4 | Count register |

## Verification
A table of vectors tries each mode with the carry-in both held and asserted, and with operands at 0, 15 and mid values. This separates true overflow and borrow from a carry that only passes through. An exhaustive sweep of all operand pairs in add and equality modes distinguishes a correct generate/propagate chain from one with a broken bit position. Four chained slices run 16-bit cases whose carries ripple across every nibble boundary. These cases separate borrow polarity in counting down from no-borrow polarity in subtraction. The count register is stepped up, held and stepped down past zero, and is shown to ignore its enable outside counter mode.

// File: rtl/nib_pkg.sv
package nib_pkg;
  typedef enum logic [1:0] {
    MD_ADDSUB = 2'b00,
    MD_COUNT  = 2'b01,
    MD_MULACC = 2'b10,
    MD_EQUAL  = 2'b11
  } nib_mode_e;

  typedef enum logic [1:0] {
    CS_FAST = 2'b00,
    CS_BHI  = 2'b01,
    CS_ZERO = 2'b10,
    CS_ONE  = 2'b11
  } nib_csrc_e;

  // carry of one generate/propagate stage
  function automatic logic gp_carry(input logic g, input logic p, input logic c);
    return g | (p & c);
  endfunction

  // sum bit of one stage
  function automatic logic gp_sum(input logic p, input logic c);
    return p ^ c;
  endfunction
endpackage

// File: rtl/nib_cin_sel.sv
module nib_cin_sel
  import nib_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       fast_in,
  input  logic       b_hi,
  output logic       cin
);
  always_comb begin
    unique case (nib_csrc_e'(sel))
      CS_FAST: cin = fast_in;
      CS_BHI:  cin = b_hi;
      CS_ZERO: cin = 1'b0;
      default: cin = 1'b1;
    endcase
  end
endmodule

// File: rtl/nib_operand_prep.sv
module nib_operand_prep
  import nib_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [1:0]   mode,
  input  logic         ctl,
  input  logic         cin,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] opnd,
  output logic         chain_cin,
  output logic         flip_carry,
  output logic         eq_mode
);
  always_comb begin
    opnd       = b_in;
    chain_cin  = cin;
    flip_carry = 1'b0;
    eq_mode    = 1'b0;
    unique case (nib_mode_e'(mode))
      MD_ADDSUB: opnd = ctl ? ~b_in : b_in;
      MD_COUNT: begin
        if (ctl) begin
          opnd = '0;
        end else begin
          // A - c = A + all-ones + ~c; borrow is the inverted carry
          opnd       = '1;
          chain_cin  = ~cin;
          flip_carry = 1'b1;
        end
      end
      MD_MULACC: opnd = ctl ? b_in : '0;
      default: begin
        chain_cin = 1'b0;
        eq_mode   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/nib_gp_chain.sv
module nib_gp_chain
  import nib_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic [W-1:0] prop,
  output logic         cout
);
  logic [W:0]   c;
  logic [W-1:0] gen;

  assign c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen[i]  = a[i] & b[i];
    assign prop[i] = a[i] ^ b[i];
    assign c[i+1]  = gp_carry(gen[i], prop[i], c[i]);
    assign sum[i]  = gp_sum(prop[i], c[i]);
  end

  assign cout = c[W];
endmodule

// File: rtl/nib_count_reg.sv
module nib_count_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/nib_arith_slice.sv
module nib_arith_slice
  import nib_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W:0]   op_a,
  input  logic [W:0]   op_b,
  input  logic         fast_cin,
  input  logic [1:0]   mode_sel,
  input  logic [1:0]   cin_src,
  input  logic [1:0]   carry_route,
  input  logic         cnt_loop,
  input  logic         cnt_en,
  output logic [W-1:0] res_f,
  output logic         cout,
  output logic         aux_out,
  output logic [W-1:0] cnt_q
);
  localparam int SW = W + 1;

  logic         cin_v;
  logic         ctl;
  logic         is_count;
  logic [W-1:0] a_low;
  logic [W-1:0] b_low;
  logic [W-1:0] opnd;
  logic         chain_cin;
  logic         flip_carry;
  logic         eq_mode;
  logic [W-1:0] chain_sum;
  logic [W-1:0] chain_prop;
  logic         chain_cout;
  logic         slice_carry;
  logic         cnt_ld;
  logic [SW-1:0] ref_add;

  assign ctl      = op_a[W];
  assign b_low    = op_b[W-1:0];
  assign is_count = (nib_mode_e'(mode_sel) == MD_COUNT);
  assign a_low    = (is_count && cnt_loop) ? cnt_q : op_a[W-1:0];
  assign cnt_ld   = cnt_en && is_count;

  nib_cin_sel u_cin (
    .sel     (cin_src),
    .fast_in (fast_cin),
    .b_hi    (op_b[W]),
    .cin     (cin_v)
  );

  nib_operand_prep #(.W(W)) u_prep (
    .mode       (mode_sel),
    .ctl        (ctl),
    .cin        (cin_v),
    .b_in       (b_low),
    .opnd       (opnd),
    .chain_cin  (chain_cin),
    .flip_carry (flip_carry),
    .eq_mode    (eq_mode)
  );

  nib_gp_chain #(.W(W)) u_chain (
    .a    (a_low),
    .b    (opnd),
    .cin  (chain_cin),
    .sum  (chain_sum),
    .prop (chain_prop),
    .cout (chain_cout)
  );

  always_comb begin
    if (eq_mode) begin
      res_f       = chain_prop;
      slice_carry = (|chain_prop) | cin_v;
    end else begin
      res_f       = chain_sum;
      slice_carry = flip_carry ? ~chain_cout : chain_cout;
    end
  end

  assign cout    = carry_route[0] & slice_carry;
  assign aux_out = carry_route[1] & slice_carry;

  nib_count_reg #(.W(W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (cnt_ld),
    .d     (res_f),
    .q     (cnt_q)
  );

  // plain-adder reference for the assertions, independent of the g/p chain
  assign ref_add = {1'b0, a_low} + {1'b0, b_low} + SW'(cin_v);

  a_r2_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 && !ctl) |-> ({slice_carry, res_f} == ref_add));

  a_r3_sub_noborrow: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 && ctl && cin_v) |-> (slice_carry == (a_low >= b_low)));

  a_r5_down_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01 && !ctl) |-> (slice_carry == (cin_v && a_low == '0)));

  a_r7_eq_match: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b11 && !cin_v && a_low == b_low) |-> (!slice_carry && res_f == '0));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_ld |=> $stable(cnt_q));

  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ld |=> (cnt_q == $past(res_f)));

  a_r10_loop_up: assert property (@(posedge clk) disable iff (!rst_n)
    (is_count && cnt_loop && ctl && cin_v) |-> (res_f == W'(cnt_q + 1'b1)));
endmodule

// File: tb/sim_nib_arith_slice.sv
module sim_nib_arith_slice;
  localparam int CLK_P = 10;
  localparam int NV = 18;

  // {mode, cin_src, op_a[4:0], op_b[4:0], fast, exp_f, exp_c}
  localparam logic [19:0] TV [0:NV-1] = '{
    {2'd0, 2'd2, 5'b00011, 5'b00101, 1'b0, 4'd8,  1'b0}, // R2
    {2'd0, 2'd3, 5'b01111, 5'b00001, 1'b0, 4'd1,  1'b1}, // R2 R1 one
    {2'd0, 2'd0, 5'b00111, 5'b01000, 1'b1, 4'd0,  1'b1}, // R1 fast
    {2'd0, 2'd1, 5'b00010, 5'b10010, 1'b0, 4'd5,  1'b0}, // R1 b_hi
    {2'd0, 2'd3, 5'b10111, 5'b00011, 1'b0, 4'd4,  1'b1}, // R3
    {2'd0, 2'd3, 5'b10011, 5'b00101, 1'b0, 4'd14, 1'b0}, // R3 borrow
    {2'd1, 2'd3, 5'b11111, 5'b00000, 1'b0, 4'd0,  1'b1}, // R4 wrap
    {2'd1, 2'd3, 5'b10110, 5'b00000, 1'b0, 4'd7,  1'b0}, // R4
    {2'd1, 2'd3, 5'b00000, 5'b00000, 1'b0, 4'd15, 1'b1}, // R5 borrow
    {2'd1, 2'd3, 5'b01001, 5'b00000, 1'b0, 4'd8,  1'b0}, // R5
    {2'd1, 2'd2, 5'b10101, 5'b00000, 1'b0, 4'd5,  1'b0}, // R4 no step
    {2'd2, 2'd2, 5'b11010, 5'b00111, 1'b0, 4'd1,  1'b1}, // R6 add
    {2'd2, 2'd2, 5'b01010, 5'b00111, 1'b0, 4'd10, 1'b0}, // R6 pass
    {2'd2, 2'd3, 5'b10011, 5'b00100, 1'b0, 4'd8,  1'b0}, // R6 with cin
    {2'd3, 2'd2, 5'b01001, 5'b01001, 1'b0, 4'd0,  1'b0}, // R7 equal
    {2'd3, 2'd2, 5'b01001, 5'b01011, 1'b0, 4'd2,  1'b1}, // R7 differ
    {2'd3, 2'd0, 5'b00101, 5'b00101, 1'b1, 4'd0,  1'b1}, // R7 cascade in
    {2'd3, 2'd1, 5'b00011, 5'b10011, 1'b0, 4'd0,  1'b1}  // R7 b_hi in
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] op_a = '0;
  logic [4:0] op_b = '0;
  logic       fast_cin = 1'b0;
  logic [1:0] mode_sel = '0;
  logic [1:0] cin_src = '0;
  logic [1:0] carry_route = 2'b11;
  logic       cnt_loop = 1'b0;
  logic       cnt_en = 1'b0;
  logic [3:0] res_f;
  logic       cout;
  logic       aux_out;
  logic [3:0] cnt_q;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  nib_arith_slice u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .fast_cin(fast_cin),
    .mode_sel(mode_sel), .cin_src(cin_src), .carry_route(carry_route),
    .cnt_loop(cnt_loop), .cnt_en(cnt_en), .res_f(res_f), .cout(cout),
    .aux_out(aux_out), .cnt_q(cnt_q)
  );

  // four-slice chain for R11
  logic [15:0] ca = '0;
  logic [15:0] cb = '0;
  logic        c_ctl = 1'b0;
  logic [1:0]  c_mode = '0;
  logic [1:0]  c_csrc = 2'd2;
  logic [4:0]  cc;
  logic [15:0] cf;
  logic [3:0]  caux;
  logic [3:0]  cq [4];

  assign cc[0] = 1'b0;
  for (genvar s = 0; s < 4; s++) begin : g_chain
    nib_arith_slice u_s (
      .clk(clk), .rst_n(rst_n),
      .op_a({c_ctl, ca[4*s +: 4]}), .op_b({1'b0, cb[4*s +: 4]}),
      .fast_cin(cc[s]), .mode_sel(c_mode),
      .cin_src(s == 0 ? c_csrc : 2'd0), .carry_route(2'b01),
      .cnt_loop(1'b0), .cnt_en(1'b0), .res_f(cf[4*s +: 4]),
      .cout(cc[s+1]), .aux_out(caux[s]), .cnt_q(cq[s])
    );
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    // R9 reset state
    @(posedge clk);
    @(negedge clk);
    check("R9 reset cnt_q", int'(cnt_q), 0);
    rst_n = 1'b1;

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {mode_sel, cin_src, op_a, op_b, fast_cin} = TV[i][19:5];
      carry_route = 2'b11;
      #1;
      check($sformatf("R%0s vec%0d f", "x", i), int'(res_f), int'(TV[i][4:1]));
      check($sformatf("vec%0d cout R8", i), int'(cout), int'(TV[i][0]));
      check($sformatf("vec%0d aux R8", i), int'(aux_out), int'(TV[i][0]));
    end

    // R8 routing: A=15,B=1,cin=1 gives carry 1
    @(negedge clk);
    mode_sel = 2'd0; cin_src = 2'd3; op_a = 5'b01111; op_b = 5'b00001;
    carry_route = 2'b01; #1;
    check("R8 ded only cout", int'(cout), 1);
    check("R8 ded only aux", int'(aux_out), 0);
    carry_route = 2'b10; #1;
    check("R8 aux only cout", int'(cout), 0);
    check("R8 aux only aux", int'(aux_out), 1);
    carry_route = 2'b00; #1;
    check("R8 none", int'({cout, aux_out}), 0);
    carry_route = 2'b11;

    // exhaustive add sweep (R2) and equality sweep (R7)
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        mode_sel = 2'd0; cin_src = 2'd0; fast_cin = 1'(a ^ b);
        op_a = {1'b0, 4'(a)}; op_b = {1'b0, 4'(b)}; #1;
        check("R2 sweep", int'({cout, res_f}), a + b + ((a ^ b) & 1));
        mode_sel = 2'd3; cin_src = 2'd2; #1;
        check("R7 sweep", int'({cout, res_f}), ((a != b) ? 16 : 0) + (a ^ b));
      end
    end

    // R9 R10 registered counter
    @(negedge clk);
    mode_sel = 2'd1; cin_src = 2'd3; op_a = 5'b10000; op_b = '0;
    cnt_loop = 1'b1; cnt_en = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R9 count up 5", int'(cnt_q), 5);
    check("R10 loop f", int'(res_f), 6);
    cnt_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 hold", int'(cnt_q), 5);
    op_a = 5'b00000; cnt_en = 1'b1;
    repeat (7) @(posedge clk);
    @(negedge clk);
    check("R9 count down past 0", int'(cnt_q), 14);
    check("R10 loop down f", int'(res_f), 13);
    // non-counter mode: enable and loop have no effect
    mode_sel = 2'd0; cin_src = 2'd2; op_a = 5'b00001; op_b = 5'b00010;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9 no load outside counter", int'(cnt_q), 14);
    check("R10 loop ignored", int'(res_f), 3);
    cnt_en = 1'b0; cnt_loop = 1'b0;
    rst_n = 1'b0; #1;
    check("R9 async reset", int'(cnt_q), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R11 cascade
    @(negedge clk);
    c_mode = 2'd0; c_ctl = 1'b0; c_csrc = 2'd2; ca = 16'hFFFF; cb = 16'h0001; #1;
    check("R11 add wrap", int'({cc[4], cf}), 32'h10000);
    ca = 16'h1234; cb = 16'h4321; #1;
    check("R11 add", int'({cc[4], cf}), 32'h05555);
    c_ctl = 1'b1; c_csrc = 2'd3; ca = 16'h1000; cb = 16'h0001; #1;
    check("R11 sub", int'({cc[4], cf}), 32'h10FFF);
    c_mode = 2'd1; c_ctl = 1'b1; ca = 16'h00FF; cb = '0; #1;
    check("R11 count up", int'({cc[4], cf}), 32'h00100);
    c_ctl = 1'b0; ca = 16'h0100; #1;
    check("R11 count down", int'({cc[4], cf}), 32'h000FF);
    c_mode = 2'd3; c_csrc = 2'd2; ca = 16'hABCD; cb = 16'hABCD; #1;
    check("R11 eq same", int'(cc[4]), 0);
    cb = 16'hABCF; #1;
    check("R11 eq low diff", int'(cc[4]), 1);
    cb = 16'h1BCD; #1;
    check("R11 eq high diff", int'(cc[4]), 1);

    finish_run();
  end
endmodule